// File: doc/BRIEF.md
# Round-Robin DMA Request Fairness Gate

This block sits between a set of DMA request lines and the logic that picks one of them for service. It gives each request line its own small state machine. The machine records that its channel has just been served. Until no other requester is left waiting, it then masks that channel's request. A channel that has finished a transfer cannot claim the bus again while another channel, or another device on the bus, still wants it. Bus arbitration and request priority are handled downstream, not here.

There are four channels by default, in the order receive 1, receive 2, transmit 1 and transmit 2 (indices 0 to 3). Each machine has four states:

- IDLE: waiting for the channel's own request.
- XFR: the channel is being served.
- FAIR: the channel's request is held back.
- TEMP: a single clock of release before the return to IDLE.

The transitions are:

- IDLE to XFR: the own request is high.
- XFR to FAIR: the own request drops.
- FAIR stays in FAIR: at least one other raw request or the bus preempt input is high.
- FAIR to TEMP: nothing else is pending.
- TEMP to IDLE: always, on the next clock.

A synchronous channel clear and a low fairness enable both force every machine to IDLE.

Top module: `dma_fair_ctrl`

## Requirements
- R1: While `rst_n` is low, `fair_flag` and `req_gated` are all zero.
- R2: With `fair_en` high, a machine in IDLE whose own `req_raw` bit is high moves to XFR on the next clock. This is observable through the later entry into FAIR.
- R3: A machine in XFR moves to FAIR on the clock edge at which its own request is sampled low. `fair_flag[i]` is high exactly while machine i is in FAIR.
- R4: A machine in FAIR stays in FAIR on each edge at which any other channel's `req_raw` bit is high.
- R5: A machine in FAIR moves to TEMP on an edge at which no other raw request and no preempt is high. From TEMP it moves to IDLE on the next edge whatever the inputs are.
- R6: `req_gated[i]` is registered. After each edge it equals the `req_raw[i]` sampled at that edge, ANDed with NOT(`fair_en` AND `fair_flag[i]`), both as they stood before that edge.
- R7: While `fair_en` is low, every machine is forced to IDLE on each edge, so `fair_flag` is zero one clock later and the raw requests pass through ungated.
- R8: `chan_clr` high at an edge forces every machine to IDLE, overriding all other inputs.
- R9: `bus_preempt` high counts as a pending request for every machine in FAIR and keeps it in FAIR, even with no raw request active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_clr | input | 1 | Synchronous clear of all machines to IDLE |
| fair_en | input | 1 | Fairness enable; low passes requests ungated |
| bus_preempt | input | 1 | Another bus device is waiting for the bus |
| req_raw | input | 4 | Raw DMA requests, bit 0 RX1, 1 RX2, 2 TX1, 3 TX2 |
| req_gated | output | 4 | Registered requests after fairness masking |
| fair_flag | output | 4 | High while the matching channel is held in FAIR |

## Verification
The assertions assume that all inputs change only between clock edges and hold a defined value at each edge. They also assume that `chan_clr` and `fair_en` act as ordinary synchronous levels with no relation required between them. The stimulus drives every input on the falling edge of the clock, so each rising edge samples settled values. The directed sequences walk a channel through XFR, FAIR and TEMP. These sequences include holding FAIR with the preempt input alone, re-requesting while in TEMP, and dropping the enable or pulsing the clear while a channel is in FAIR. A pseudo-random phase then mixes all inputs, keeping `chan_clr` rare so that the machines can reach deep states.

// File: rtl/dma_fair_pkg.sv
package dma_fair_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFR  = 2'd1,
        ST_FAIR = 2'd2,
        ST_TEMP = 2'd3
    } fair_state_t;

endpackage

// File: rtl/dma_fair_chan.sv
module dma_fair_chan
    import dma_fair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_clr,
    input  logic fair_en,
    input  logic own_req,
    input  logic others_busy,
    output logic fair_flag
);

    fair_state_t state_q;
    fair_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (chan_clr || !fair_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (own_req)      state_d = ST_XFR;
                ST_XFR:  if (!own_req)     state_d = ST_FAIR;
                ST_FAIR: if (!others_busy) state_d = ST_TEMP;
                ST_TEMP: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        fair_flag = (state_q == ST_FAIR);
    end

    // R8
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clr |=> (state_q == ST_IDLE));

    // R5
    temp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEMP) |=> (state_q == ST_IDLE));

    // R4
    fair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIR && others_busy && fair_en && !chan_clr) |=> fair_flag);

    // R3
    xfr_fair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFR && !own_req && fair_en && !chan_clr) |=> (state_q == ST_FAIR));

endmodule

// File: rtl/dma_fair_gate.sv
module dma_fair_gate #(
    parameter int N_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] req_in,
    input  logic [N_CHAN-1:0] block,
    output logic [N_CHAN-1:0] req_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_out <= '0;
        else        req_out <= req_in & ~block;
    end

endmodule

// File: rtl/dma_fair_ctrl.sv
module dma_fair_ctrl #(
    parameter int N_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_clr,
    input  logic              fair_en,
    input  logic              bus_preempt,
    input  logic [N_CHAN-1:0] req_raw,
    output logic [N_CHAN-1:0] req_gated,
    output logic [N_CHAN-1:0] fair_flag
);

    logic [N_CHAN-1:0] others_busy;
    logic [N_CHAN-1:0] block;

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        logic [N_CHAN-1:0] mask;
        always_comb begin
            mask           = '1;
            mask[i]        = 1'b0;
            others_busy[i] = (|(req_raw & mask)) | bus_preempt;
        end

        dma_fair_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .chan_clr    (chan_clr),
            .fair_en     (fair_en),
            .own_req     (req_raw[i]),
            .others_busy (others_busy[i]),
            .fair_flag   (fair_flag[i])
        );

        // R6
        gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fair_en && fair_flag[i]) |=> !req_gated[i]);

        // R9
        preempt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fair_flag[i] && bus_preempt && fair_en && !chan_clr) |=> fair_flag[i]);
    end

    assign block = fair_flag & {N_CHAN{fair_en}};

    dma_fair_gate #(.N_CHAN(N_CHAN)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_raw),
        .block   (block),
        .req_out (req_gated)
    );

    // R7
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fair_en |=> (fair_flag == '0));

    // R1
    always_comb begin
        if (!rst_n) reset_out_chk: assert final ((req_gated == '0) && (fair_flag == '0));
    end

endmodule

// File: tb/dma_fair_ctrl_test.sv
`timescale 1ns/1ps
module dma_fair_ctrl_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         chan_clr = 1'b0;
    logic         fair_en = 1'b0;
    logic         bus_preempt = 1'b0;
    logic [N-1:0] req_raw = '0;
    logic [N-1:0] req_gated;
    logic [N-1:0] fair_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic [N-1:0] gated;
        logic [N-1:0] flag;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // model states: 0 IDLE, 1 XFR, 2 FAIR, 3 TEMP
    int mst[N];

    always #2.5 clk = ~clk;

    dma_fair_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_clr    (chan_clr),
        .fair_en     (fair_en),
        .bus_preempt (bus_preempt),
        .req_raw     (req_raw),
        .req_gated   (req_gated),
        .fair_flag   (fair_flag)
    );

    // Driver: applies one vector and predicts the outputs after the next edge
    task automatic step(input logic [N-1:0] raw, input logic pre,
                        input logic en, input logic clr, input string tag);
        exp_t e;
        @(negedge clk);
        req_raw     = raw;
        bus_preempt = pre;
        fair_en     = en;
        chan_clr    = clr;
        for (int i = 0; i < N; i++) begin
            logic oth;
            int   nx;
            oth = pre;
            for (int j = 0; j < N; j++) if (j != i && raw[j]) oth = 1'b1;
            e.gated[i] = raw[i] & ~(en & (mst[i] == 2));
            nx = mst[i];
            if (clr || !en) nx = 0;
            else case (mst[i])
                0: if (raw[i]) nx = 1;
                1: if (!raw[i]) nx = 2;
                2: if (!oth) nx = 3;
                default: nx = 0;
            endcase
            mst[i]    = nx;
            e.flag[i] = (nx == 2);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (req_gated !== e.gated || fair_flag !== e.flag) begin
                    n_bad++;
                    $display("FAIL %s: gated=%b flag=%b expected gated=%b flag=%b",
                             t, req_gated, fair_flag, e.gated, e.flag);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < N; i++) mst[i] = 0;
        // R1: outputs cleared in reset
        req_raw = 4'b1111;
        fair_en = 1'b1;
        repeat (3) @(negedge clk);
        n_vec++;
        if (req_gated !== '0 || fair_flag !== '0) begin
            n_bad++;
            $display("FAIL R1: gated=%b flag=%b expected gated=0000 flag=0000",
                     req_gated, fair_flag);
        end
        req_raw = '0;
        rst_n   = 1'b1;

        // R2, R3: RX1 served then held
        step(4'b0001, 0, 1, 0, "R2");
        step(4'b0001, 0, 1, 0, "R2");
        step(4'b0010, 0, 1, 0, "R3");
        // R4, R6: RX1 masked while RX2 pending
        step(4'b0011, 0, 1, 0, "R6");
        step(4'b0011, 0, 1, 0, "R4");
        step(4'b0001, 0, 1, 0, "R4");
        // R5: release through TEMP to IDLE
        step(4'b0000, 0, 1, 0, "R5");
        step(4'b0000, 0, 1, 0, "R5");
        step(4'b0000, 0, 1, 0, "R5");

        // R9: preempt alone keeps TX1 in FAIR
        step(4'b0100, 0, 1, 0, "R9");
        step(4'b0000, 1, 1, 0, "R9");
        step(4'b0100, 1, 1, 0, "R9");
        step(4'b0000, 1, 1, 0, "R9");
        step(4'b0000, 0, 1, 0, "R5");
        // R5: own request during TEMP still returns to IDLE
        step(4'b0100, 0, 1, 0, "R5");
        step(4'b0100, 0, 1, 0, "R5");
        step(4'b0000, 0, 1, 0, "R5");
        step(4'b0000, 0, 1, 0, "R5");

        // R7: enable dropped while TX2 held in FAIR
        step(4'b1000, 0, 1, 0, "R7");
        step(4'b0001, 0, 1, 0, "R7");
        step(4'b1001, 0, 0, 0, "R7");
        step(4'b1001, 0, 0, 0, "R7");
        step(4'b1001, 0, 1, 0, "R7");
        step(4'b0000, 0, 1, 0, "R7");

        // R8: clear while in FAIR and while requesting
        step(4'b0010, 0, 1, 0, "R8");
        step(4'b0100, 0, 1, 0, "R8");
        step(4'b0110, 1, 1, 1, "R8");
        step(4'b0110, 1, 1, 0, "R8");
        step(4'b0000, 1, 1, 0, "R8");

        // R6: pseudo-random mix
        lfsr = 8'hA5;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[3:0], lfsr[4] & lfsr[6], ~(lfsr[5] & lfsr[7] & lfsr[2]),
                 (lfsr == 8'h3C) || (lfsr[7:2] == 6'h2A), "R6");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule